// File: doc/BRIEF.md
# AC-link Input Frame Deserializer

This block sits on the receive side of an AC97-style serial audio link. The codec supplies the bit clock and a serial data line. The controller generates a frame strobe that marks where each input frame begins. The block shifts the data in and reads the tag word at the head of every frame. It then routes the payload of selected slots into three capture streams: a stereo recording pair, a modem line ADC channel, and an auxiliary microphone-or-headset channel. A configuration input chooses which of two slots feeds the auxiliary channel.

Each stream holds one sample behind a valid/ready handshake. A consumer in the bit-clock domain takes the sample when it is ready. If the consumer lags, the newer sample replaces the older one and a sticky overrun flag records the loss. The low bits of each 20-bit slot are dropped, and only tagged slots in a frame marked valid produce samples.

Top module: `acl_rx_deframer`

## Requirements
- R1: A frame begins with the bit sampled at the first falling edge of `bit_clk` where `frame_sync` is high after having been low at the previous falling edge. A frame is a 16-bit tag slot followed by twelve 20-bit slots, 256 bits in all. Bits after the 256th are ignored until the next such rise of `frame_sync`.
- R2: `sdata_in` is sampled on the falling edge of `bit_clk`, and every slot arrives most significant bit first.
- R3: In the 16-bit tag slot, bit 15 (the first bit received) is the frame-valid flag, and bit 15-n tags slot n. A slot produces a sample only when both the frame-valid flag and its own tag bit are 1.
- R4: A sample is the upper 16 bits of its 20-bit slot. The lowest 4 bits are discarded.
- R5: The stereo stream presents `{slot 3 sample, slot 4 sample}` as one 32-bit word, with slot 3 in bits 31:16. It is presented at the falling edge that ends slot 4, and only when both slot 3 and slot 4 are tagged valid.
- R6: The modem stream carries the slot 5 sample and is presented at the falling edge that ends slot 5.
- R7: The auxiliary stream carries the slot 6 sample when `aux_slot_sel` is 0 and the slot 11 sample when it is 1. The select is read at the end of the slot.
- R8: A presented sample holds its valid and data unchanged until `*_ready` is high at a falling edge. The sample is then taken and valid drops at that edge.
- R9: A new sample that arrives while the stream holds one that is not being taken in the same edge overwrites the data and sets that stream's overrun flag, which then stays set. A new sample arriving in the edge that takes the old one sets no overrun and leaves valid high with the new data.
- R10: While `rst_n` is low, every valid and overrun output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Bit clock from the codec; everything acts on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync | input | 1 | Locally generated frame strobe; its rise starts a frame |
| sdata_in | input | 1 | Serial input data from the codec |
| aux_slot_sel | input | 1 | 0 = auxiliary stream from slot 6, 1 = from slot 11 |
| pcm_ready | input | 1 | Consumer takes the stereo sample |
| pcm_valid | output | 1 | Stereo sample available |
| pcm_data | output | 32 | Left (31:16) and right (15:0) samples |
| pcm_overrun | output | 1 | Sticky: a stereo sample was lost |
| modem_ready | input | 1 | Consumer takes the modem sample |
| modem_valid | output | 1 | Modem sample available |
| modem_data | output | 16 | Modem line ADC sample |
| modem_overrun | output | 1 | Sticky: a modem sample was lost |
| aux_ready | input | 1 | Consumer takes the auxiliary sample |
| aux_valid | output | 1 | Auxiliary sample available |
| aux_data | output | 16 | Microphone or headset sample |
| aux_overrun | output | 1 | Sticky: an auxiliary sample was lost |

## Verification
The delicate coincidence is a new sample landing on a stream in the same falling edge where the consumer takes the previous one. The bench holds a stereo sample unread across a frame. It then raises `pcm_ready` only for the edge that closes slot 4 of the next frame. The result must be: valid still high, data equal to the new pair, and no stereo overrun. In the same frame, the modem stream is left unread, so its overrun must be set. A sweep over every combination of the frame-valid flag, the relevant slot tags and the auxiliary select checks that samples appear only where the tags allow them.

// File: rtl/acl_pkg.sv
package acl_pkg;

   // Position of the tag bit for a given slot inside the tag word (slot 0 = frame valid).
   function automatic int unsigned tag_index(input int unsigned tag_w, input int unsigned slot);
      return tag_w - 1 - slot;
   endfunction

endpackage

// File: rtl/acl_frame_pos.sv
module acl_frame_pos #(
   parameter int unsigned SLOT0_W   = 16,
   parameter int unsigned SLOT_W    = 20,
   parameter int unsigned NUM_SLOTS = 12,
   localparam int unsigned IDX_W    = $clog2(NUM_SLOTS + 2),
   localparam int unsigned BIT_W    = $clog2((SLOT0_W > SLOT_W) ? SLOT0_W : SLOT_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_sync,
   output logic [IDX_W-1:0] cur_slot,
   output logic             last_bit,
   output logic             active
);

   localparam logic [IDX_W-1:0] IDLE_SLOT = IDX_W'(NUM_SLOTS + 1);

   logic             sync_q;
   logic             sync_rise;
   logic [IDX_W-1:0] slot_q;
   logic [BIT_W-1:0] bit_q;
   logic [BIT_W-1:0] cur_bit;

   assign sync_rise = frame_sync & ~sync_q;

   always_comb begin
      if (sync_rise) begin
         cur_slot = '0;
         cur_bit  = '0;
      end else begin
         cur_slot = slot_q;
         cur_bit  = bit_q;
      end
      active   = (cur_slot <= IDX_W'(NUM_SLOTS));
      last_bit = active && (cur_bit == ((cur_slot == '0) ? BIT_W'(SLOT0_W - 1) : BIT_W'(SLOT_W - 1)));
   end

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= 1'b0;
         slot_q <= IDLE_SLOT;
         bit_q  <= '0;
      end else begin
         sync_q <= frame_sync;
         if (!active) begin
            slot_q <= IDLE_SLOT;
            bit_q  <= '0;
         end else if (last_bit) begin
            slot_q <= cur_slot + 1'b1;
            bit_q  <= '0;
         end else begin
            slot_q <= cur_slot;
            bit_q  <= cur_bit + 1'b1;
         end
      end
   end

   // Inside a slot the index may only change at its last bit or on a new frame.
   assert_slot_steady_R1: assert property (@(negedge clk) disable iff (!rst_n)
      (active && !last_bit) |=> (sync_rise || (cur_slot == $past(cur_slot))));

endmodule

// File: rtl/acl_slot_shift.sv
module acl_slot_shift #(
   parameter int unsigned SLOT_W = 20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              sdata,
   output logic [SLOT_W-1:0] word_now
);

   generate
      if (SLOT_W > 1) begin : g_shift
         logic [SLOT_W-2:0] shreg;
         always_ff @(negedge clk or negedge rst_n) begin
            if (!rst_n)        shreg <= '0;
            else if (shift_en) shreg <= {shreg[SLOT_W-3 >= 0 ? SLOT_W-3 : 0:0], sdata} & {(SLOT_W-1){1'b1}};
         end
         assign word_now = {shreg, sdata};
      end else begin : g_single
         assign word_now = sdata;
      end
   endgenerate

endmodule

// File: rtl/acl_cap_stream.sv
module acl_cap_stream #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         ready,
   output logic         valid,
   output logic [W-1:0] data,
   output logic         overrun
);

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid   <= 1'b0;
         data    <= '0;
         overrun <= 1'b0;
      end else begin
         if (push) begin
            data  <= push_data;
            valid <= 1'b1;
            if (valid && !ready) overrun <= 1'b1;
         end else if (valid && ready) begin
            valid <= 1'b0;
         end
      end
   end

   assert_overrun_sticky_R9: assert property (@(negedge clk) disable iff (!rst_n)
      overrun |=> overrun);

   assert_push_presents_R9: assert property (@(negedge clk) disable iff (!rst_n)
      push |=> (valid && data == $past(push_data)));

   assert_hold_unread_R8: assert property (@(negedge clk) disable iff (!rst_n)
      (valid && !ready && !push) |=> (valid && $stable(data)));

endmodule

// File: rtl/acl_rx_deframer.sv
module acl_rx_deframer #(
   parameter int unsigned SAMPLE_W   = 16,
   parameter int unsigned SLOT_W     = 20,
   parameter int unsigned SLOT0_W    = 16,
   parameter int unsigned NUM_SLOTS  = 12,
   parameter int unsigned PCM_L_SLOT = 3,
   parameter int unsigned PCM_R_SLOT = 4,
   parameter int unsigned MODEM_SLOT = 5,
   parameter int unsigned AUX_SLOT_A = 6,
   parameter int unsigned AUX_SLOT_B = 11
) (
   input  logic                  bit_clk,
   input  logic                  rst_n,
   input  logic                  frame_sync,
   input  logic                  sdata_in,
   input  logic                  aux_slot_sel,
   input  logic                  pcm_ready,
   output logic                  pcm_valid,
   output logic [2*SAMPLE_W-1:0] pcm_data,
   output logic                  pcm_overrun,
   input  logic                  modem_ready,
   output logic                  modem_valid,
   output logic [SAMPLE_W-1:0]   modem_data,
   output logic                  modem_overrun,
   input  logic                  aux_ready,
   output logic                  aux_valid,
   output logic [SAMPLE_W-1:0]   aux_data,
   output logic                  aux_overrun
);

   import acl_pkg::*;

   localparam int unsigned IDX_W  = $clog2(NUM_SLOTS + 2);
   localparam int unsigned WORD_W = (SLOT0_W > SLOT_W) ? SLOT0_W : SLOT_W;

   generate
      if (SAMPLE_W > SLOT_W) begin : g_bad_sample
         $error("SAMPLE_W must not exceed SLOT_W");
      end
      if (SLOT0_W < NUM_SLOTS + 1) begin : g_bad_tags
         $error("tag slot too narrow for the slot count");
      end
      if (SLOT0_W > SLOT_W) begin : g_bad_slot0
         $error("tag slot must not be wider than a data slot");
      end
      if (PCM_L_SLOT >= PCM_R_SLOT || PCM_R_SLOT > NUM_SLOTS || MODEM_SLOT > NUM_SLOTS ||
          AUX_SLOT_A > NUM_SLOTS || AUX_SLOT_B > NUM_SLOTS ||
          PCM_L_SLOT == 0 || MODEM_SLOT == 0 || AUX_SLOT_A == 0 || AUX_SLOT_B == 0) begin : g_bad_map
         $error("capture slot numbers out of range");
      end
   endgenerate

   logic [IDX_W-1:0]  cur_slot;
   logic              last_bit;
   logic              active;
   logic [WORD_W-1:0] word_now;
   logic              slot_end;
   logic [SLOT0_W-1:0] tags_q;
   logic              frame_ok;
   logic              tag_cur;
   logic [SAMPLE_W-1:0] sample;
   logic [SAMPLE_W-1:0] left_q;
   logic              left_ok_q;
   logic [IDX_W-1:0]  aux_slot;
   logic              pcm_push;
   logic              modem_push;
   logic              aux_push;

   acl_frame_pos #(
      .SLOT0_W  (SLOT0_W),
      .SLOT_W   (SLOT_W),
      .NUM_SLOTS(NUM_SLOTS)
   ) u_pos (
      .clk       (bit_clk),
      .rst_n     (rst_n),
      .frame_sync(frame_sync),
      .cur_slot  (cur_slot),
      .last_bit  (last_bit),
      .active    (active)
   );

   acl_slot_shift #(
      .SLOT_W(WORD_W)
   ) u_shift (
      .clk     (bit_clk),
      .rst_n   (rst_n),
      .shift_en(active),
      .sdata   (sdata_in),
      .word_now(word_now)
   );

   assign slot_end = active && last_bit;
   assign frame_ok = tags_q[SLOT0_W-1];
   assign sample   = word_now[SLOT_W-1 -: SAMPLE_W];
   assign aux_slot = aux_slot_sel ? IDX_W'(AUX_SLOT_B) : IDX_W'(AUX_SLOT_A);

   always_comb begin
      tag_cur = 1'b0;
      for (int unsigned s = 1; s <= NUM_SLOTS; s++) begin
         if (cur_slot == IDX_W'(s)) tag_cur = tags_q[tag_index(SLOT0_W, s)];
      end
   end

   always_ff @(negedge bit_clk or negedge rst_n) begin
      if (!rst_n) begin
         tags_q    <= '0;
         left_q    <= '0;
         left_ok_q <= 1'b0;
      end else if (slot_end) begin
         if (cur_slot == '0) begin
            tags_q    <= word_now[SLOT0_W-1:0];
            left_ok_q <= 1'b0;
         end else if (cur_slot == IDX_W'(PCM_L_SLOT)) begin
            left_q    <= sample;
            left_ok_q <= frame_ok && tag_cur;
         end
      end
   end

   assign pcm_push   = slot_end && frame_ok && tag_cur && left_ok_q && (cur_slot == IDX_W'(PCM_R_SLOT));
   assign modem_push = slot_end && frame_ok && tag_cur && (cur_slot == IDX_W'(MODEM_SLOT));
   assign aux_push   = slot_end && frame_ok && tag_cur && (cur_slot == aux_slot);

   acl_cap_stream #(.W(2*SAMPLE_W)) u_pcm (
      .clk(bit_clk), .rst_n(rst_n), .push(pcm_push), .push_data({left_q, sample}),
      .ready(pcm_ready), .valid(pcm_valid), .data(pcm_data), .overrun(pcm_overrun)
   );

   acl_cap_stream #(.W(SAMPLE_W)) u_modem (
      .clk(bit_clk), .rst_n(rst_n), .push(modem_push), .push_data(sample),
      .ready(modem_ready), .valid(modem_valid), .data(modem_data), .overrun(modem_overrun)
   );

   acl_cap_stream #(.W(SAMPLE_W)) u_aux (
      .clk(bit_clk), .rst_n(rst_n), .push(aux_push), .push_data(sample),
      .ready(aux_ready), .valid(aux_valid), .data(aux_data), .overrun(aux_overrun)
   );

   assert_invalid_frame_silent_R3: assert property (@(negedge bit_clk) disable iff (!rst_n)
      (slot_end && cur_slot != '0 && !frame_ok) |=> (!$rose(pcm_valid) && !$rose(modem_valid) && !$rose(aux_valid)));

   assert_stereo_at_right_R5: assert property (@(negedge bit_clk) disable iff (!rst_n)
      $rose(pcm_valid) |-> ($past(cur_slot) == IDX_W'(PCM_R_SLOT)));

   assert_modem_at_slot_R6: assert property (@(negedge bit_clk) disable iff (!rst_n)
      $rose(modem_valid) |-> ($past(cur_slot) == IDX_W'(MODEM_SLOT)));

endmodule

// File: tb/test_acl_rx_deframer.sv
module test_acl_rx_deframer;

   localparam int PERIOD = 10;

   logic        bit_clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_sync = 1'b0;
   logic        sdata_in = 1'b0;
   logic        aux_slot_sel = 1'b0;
   logic        pcm_ready = 1'b0;
   logic        modem_ready = 1'b0;
   logic        aux_ready = 1'b0;
   logic        pcm_valid, modem_valid, aux_valid;
   logic        pcm_overrun, modem_overrun, aux_overrun;
   logic [31:0] pcm_data;
   logic [15:0] modem_data, aux_data;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 0;

   always #(PERIOD/2) bit_clk = ~bit_clk;

   acl_rx_deframer i_acl_rx_deframer (
      .bit_clk(bit_clk), .rst_n(rst_n), .frame_sync(frame_sync), .sdata_in(sdata_in),
      .aux_slot_sel(aux_slot_sel),
      .pcm_ready(pcm_ready), .pcm_valid(pcm_valid), .pcm_data(pcm_data), .pcm_overrun(pcm_overrun),
      .modem_ready(modem_ready), .modem_valid(modem_valid), .modem_data(modem_data), .modem_overrun(modem_overrun),
      .aux_ready(aux_ready), .aux_valid(aux_valid), .aux_data(aux_data), .aux_overrun(aux_overrun)
   );

   function automatic logic [19:0] sval(input int seed, input int k);
      logic [31:0] x;
      x = 32'(seed) * 32'd40503 + 32'(k) * 32'd9973 + 32'h5a5;
      x = x ^ (x >> 11);
      x = x * 32'd2654435761;
      return x[31:12];
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Drive one 256-bit frame; ready_at selects a bit index at which pcm_ready pulses.
   task automatic send_frame(input logic [15:0] tags, input int seed, input int ready_at);
      for (int i = 0; i < 256; i++) begin
         @(posedge bit_clk);
         frame_sync = (i < 16);
         pcm_ready  = (i == ready_at);
         if (i < 16) sdata_in = tags[15 - i];
         else begin
            automatic int k = (i - 16) / 20 + 1;
            automatic int b = (i - 16) % 20;
            automatic logic [19:0] v = sval(seed, k);
            sdata_in = v[19 - b];
         end
      end
      // Trailing idle bits with arbitrary data (R1: ignored until next sync rise).
      for (int i = 0; i < 4; i++) begin
         @(posedge bit_clk);
         frame_sync = 1'b0;
         pcm_ready  = 1'b0;
         sdata_in   = i[0];
      end
      @(posedge bit_clk);
   endtask

   task automatic accept_all();
      @(posedge bit_clk);
      pcm_ready = 1'b1; modem_ready = 1'b1; aux_ready = 1'b1;
      @(posedge bit_clk);
      pcm_ready = 1'b0; modem_ready = 1'b0; aux_ready = 1'b0;
      @(posedge bit_clk);
      check("R8 pcm taken", {63'd0, pcm_valid}, 64'd0);
      check("R8 modem taken", {63'd0, modem_valid}, 64'd0);
      check("R8 aux taken", {63'd0, aux_valid}, 64'd0);
   endtask

   task automatic do_reset();
      @(posedge bit_clk);
      rst_n = 1'b0;
      frame_sync = 1'b0;
      repeat (3) @(posedge bit_clk);
      check("R10 pcm_valid", {63'd0, pcm_valid}, 64'd0);
      check("R10 modem_valid", {63'd0, modem_valid}, 64'd0);
      check("R10 aux_valid", {63'd0, aux_valid}, 64'd0);
      check("R10 overruns", {61'd0, pcm_overrun, modem_overrun, aux_overrun}, 64'd0);
      rst_n = 1'b1;
      repeat (2) @(posedge bit_clk);
   endtask

   initial begin
      #(PERIOD * 190000);
      if (!done) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      do_reset();

      // Sweep: frame-valid flag, tags of slots 3,4,5,6,11 and the aux select (R1..R7).
      for (int m = 0; m < 128; m++) begin
         automatic logic fv  = m[5];
         automatic logic sel = m[6];
         automatic logic [15:0] tags = 16'h0;
         automatic logic e_pcm, e_mod, e_aux;
         tags[15]      = fv;
         tags[15 - 3]  = m[0];
         tags[15 - 4]  = m[1];
         tags[15 - 5]  = m[2];
         tags[15 - 6]  = m[3];
         tags[15 - 11] = m[4];
         tags[15 - 1]  = 1'b1;
         tags[15 - 7]  = 1'b1;
         e_pcm = fv & m[0] & m[1];
         e_mod = fv & m[2];
         e_aux = fv & (sel ? m[4] : m[3]);
         aux_slot_sel = sel;
         send_frame(tags, m, -1);
         check("R3 R5 pcm_valid per tags", {63'd0, pcm_valid}, {63'd0, e_pcm});
         check("R3 R6 modem_valid per tags", {63'd0, modem_valid}, {63'd0, e_mod});
         check("R3 R7 aux_valid per tags/select", {63'd0, aux_valid}, {63'd0, e_aux});
         if (e_pcm) check("R2 R4 R5 pcm_data", {32'd0, pcm_data}, {32'd0, sval(m, 3)[19:4], sval(m, 4)[19:4]});
         if (e_mod) check("R2 R4 R6 modem_data", {48'd0, modem_data}, {48'd0, sval(m, 5)[19:4]});
         if (e_aux) check("R7 aux_data", {48'd0, aux_data}, {48'd0, sval(m, sel ? 11 : 6)[19:4]});
         check("R9 no overrun when drained", {61'd0, pcm_overrun, modem_overrun, aux_overrun}, 64'd0);
         accept_all();
      end

      // Overrun: two frames without taking (R9).
      do_reset();
      aux_slot_sel = 1'b0;
      send_frame(16'hFFFF, 500, -1);
      check("R8 pcm held unread", {63'd0, pcm_valid}, 64'd1);
      send_frame(16'hFFFF, 501, -1);
      check("R9 overruns set", {61'd0, pcm_overrun, modem_overrun, aux_overrun}, 64'h7);
      check("R9 pcm overwritten", {32'd0, pcm_data}, {32'd0, sval(501, 3)[19:4], sval(501, 4)[19:4]});
      check("R9 modem overwritten", {48'd0, modem_data}, {48'd0, sval(501, 5)[19:4]});
      accept_all();
      send_frame(16'hFFFF, 502, -1);
      check("R9 overrun sticky", {61'd0, pcm_overrun, modem_overrun, aux_overrun}, 64'h7);
      accept_all();

      // Same-edge take and new sample on the stereo stream (R9).
      do_reset();
      send_frame(16'hFFFF, 600, -1);
      send_frame(16'hFFFF, 601, 95);
      check("R9 pcm valid after same-edge take", {63'd0, pcm_valid}, 64'd1);
      check("R9 pcm new data after same-edge take", {32'd0, pcm_data}, {32'd0, sval(601, 3)[19:4], sval(601, 4)[19:4]});
      check("R9 pcm no overrun on same-edge take", {63'd0, pcm_overrun}, 64'd0);
      check("R9 modem overrun while unread", {63'd0, modem_overrun}, 64'd1);
      accept_all();

      do_reset();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

endmodule